// File: doc/BRIEF.md
# SCSI Phase-Check and Interrupt Unit

This block sits beside a SCSI protocol engine and watches the commands the host gives it. The host writes a 4-bit sequence command. For commands that expect a particular information phase, the block compares that phase with the live MSG, C/D and I/O lines. A command whose phase matches starts and stays running until the data mover outside the block pulses a done strobe. A command whose phase does not match is refused, and a phase-mismatch exception is recorded.

The block latches these exception events in an exception register:
- arbitration lost;
- reselection;
- being selected as a target, with or without ATN;
- phase mismatch;
- selection timeout.

It latches these error events in an error register:
- bus reset;
- unexpected disconnect;
- parity error;
- sequencing error.

Together with a command-done flag, the two registers form three interrupt sources. A mask register gates the sources onto one interrupt line. A programmable timer aborts a selection that runs too long. The timer counts in 10 ms units, and the length of one unit is a parameter in clock cycles.

Top module: `scsi_phase_irq`

## Requirements
- R1: After reset, exc_status, err_status and int_status are zero, and irq and busy are low.
- R2: A command with code 1 to 9 that is accepted sets busy. While busy, a pulse on xfer_done clears busy and sets int_status bit 0 (command done). The expected phase {MSG,C/D,I/O} for each code is: 3 (command) needs 010, 4 (status) needs 011, 5 (data out) needs 000, 6 (data in) needs 001, 7 (message out) needs 110 and 8 (message in) needs 111. Codes 1 (arbitrate), 2 (select) and 9 (bus free) have no phase check.
- R3: A phase command (codes 3 to 8) issued while idle, with bus_phase different from its expected phase, sets exc_status bit 1 (0x02). It leaves busy low and does not set command done.
- R4: A command with code 1 to 9 written while busy sets err_status bit 4 (0x10) and is dropped. The running command continues.
- R5: While a select (code 2) runs with a timeout value L other than 0, the selection is aborted exactly L×TICK_CYCLES cycles after the command edge. The abort sets exc_status bit 0 (0x01) and clears busy without command done. A timeout value of 0 never aborts.
- R6: arb_lost while an arbitrate (code 1) runs sets exc_status bit 2 (0x04) and clears busy without command done. arb_lost at any other time has no effect.
- R7: sel_atn_in sets exc_status bit 5 (0x20) and sel_in sets bit 4 (0x10). resel_in sets bit 3 (0x08) only after code 0xC has enabled reselection. Code 0xD disables reselection again, and reselection is disabled after reset.
- R8: disc_in sets err_status bit 6 (0x40) and bus_rst_in sets bit 5 (0x20). parity_err_in sets bit 0 (0x01) only after code 0xA has enabled parity checking. Code 0xB disables parity checking again, and it is disabled after reset.
- R9: int_status bit 2 is set whenever err_status is non-zero, bit 1 whenever exc_status is non-zero, and bit 0 is the latched command-done flag. A register write with reg_sel 2 clears the done flag where wdata bit 0 is 1. Writing 1 to bits 2 or 1 has no effect while their cause is non-zero.
- R10: irq is high exactly when int_status AND the mask is non-zero. The mask is written with reg_sel 3 from wdata[2:0] and is zero after reset.
- R11: Register writes with reg_sel 0 and reg_sel 1 clear the exc_status and err_status bits that are 1 in wdata. An event that sets a bit in the same cycle as a clear of that bit leaves the bit set. reg_sel 4 loads the selection timeout value.
- R12: Codes 0xA, 0xB, 0xC, 0xD and 0xF complete at once and set command done. Code 0xE clears exc_status, err_status, the done flag, busy and both enables, without setting done. Code 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Strobe that writes a sequence command |
| cmd_code | input | 4 | Sequence command code |
| bus_phase | input | 3 | Live {MSG, C/D, I/O} lines |
| xfer_done | input | 1 | Done strobe from the external data mover |
| arb_lost | input | 1 | Arbitration was lost |
| sel_atn_in | input | 1 | Selected as target with ATN |
| sel_in | input | 1 | Selected as target without ATN |
| resel_in | input | 1 | Reselected as initiator |
| disc_in | input | 1 | Target disconnected unexpectedly |
| bus_rst_in | input | 1 | Bus reset was seen |
| parity_err_in | input | 1 | Parity error was detected |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 3 | 0 exception clear, 1 error clear, 2 interrupt clear, 3 mask, 4 timeout |
| reg_wdata | input | 8 | Host write data |
| exc_status | output | 8 | Exception register |
| err_status | output | 8 | Error register |
| int_status | output | 3 | Interrupt sources {error, exception, done} |
| irq | output | 1 | Masked interrupt line |
| busy | output | 1 | A sequenced command is running |

## Verification
Two collisions can fall in the same cycle. In the first, an event sets an exception bit while the host write clears that same bit. The bench pulses sel_in in the cycle that writes the clear mask for bit 4, and expects bit 4 to stay set. In the second, a new sequenced command arrives while the previous one is still busy. The bench issues data-in during a running data-out, and expects the sequencing error to be raised, busy to stay high, and the later done strobe to still complete the first command.

// File: rtl/scsi_pi_pkg.sv
`timescale 1ns/1ps
package scsi_pi_pkg;
  localparam int CODE_W = 4;
  localparam int PH_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    OP_NOP      = 4'h0, OP_ARB     = 4'h1, OP_SEL     = 4'h2, OP_CMD     = 4'h3,
    OP_STAT     = 4'h4, OP_DOUT    = 4'h5, OP_DIN     = 4'h6, OP_MOUT    = 4'h7,
    OP_MIN      = 4'h8, OP_BFREE   = 4'h9, OP_PAR_ON  = 4'hA, OP_PAR_OFF = 4'hB,
    OP_RSL_ON   = 4'hC, OP_RSL_OFF = 4'hD, OP_SOFT_RST = 4'hE, OP_FLUSH  = 4'hF
  } op_e;

  typedef struct packed {
    logic            valid;
    logic [PH_W-1:0] ph;
  } phase_exp_t;

  // exception bit positions
  localparam int EXC_SELATN = 5;
  localparam int EXC_SELECT = 4;
  localparam int EXC_RESEL  = 3;
  localparam int EXC_ARBLST = 2;
  localparam int EXC_MISM   = 1;
  localparam int EXC_SELTO  = 0;
  // error bit positions
  localparam int ERR_DISC   = 6;
  localparam int ERR_BUSRST = 5;
  localparam int ERR_SEQ    = 4;
  localparam int ERR_PAR    = 0;

  function automatic phase_exp_t phase_for(input logic [CODE_W-1:0] code);
    phase_exp_t r;
    r.valid = 1'b1;
    case (code)
      OP_CMD:  r.ph = 3'b010;
      OP_STAT: r.ph = 3'b011;
      OP_DOUT: r.ph = 3'b000;
      OP_DIN:  r.ph = 3'b001;
      OP_MOUT: r.ph = 3'b110;
      OP_MIN:  r.ph = 3'b111;
      default: begin r.valid = 1'b0; r.ph = 3'b000; end
    endcase
    return r;
  endfunction

  function automatic logic is_sequenced(input logic [CODE_W-1:0] code);
    return (code >= OP_ARB) && (code <= OP_BFREE);
  endfunction

  function automatic logic is_control(input logic [CODE_W-1:0] code);
    return code >= OP_PAR_ON;
  endfunction
endpackage

// File: rtl/scsi_pi_seq.sv
`timescale 1ns/1ps
module scsi_pi_seq
  import scsi_pi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [PH_W-1:0]   bus_phase,
  input  logic              xfer_done,
  input  logic              arb_lost,
  input  logic              sel_expire,
  output logic              busy,
  output logic [CODE_W-1:0] cur_op,
  output logic              sel_run,
  output logic              par_en,
  output logic              rsl_en,
  output logic              ev_mismatch,
  output logic              ev_seqerr,
  output logic              ev_done,
  output logic              ev_arb_lost,
  output logic              ev_soft_rst
);
  phase_exp_t pexp;
  logic start, abort, finish;

  assign sel_run = busy && (cur_op == OP_SEL);

  always_comb begin
    pexp        = phase_for(cmd_code);
    ev_soft_rst = cmd_wr && (cmd_code == OP_SOFT_RST);
    ev_seqerr   = cmd_wr && busy && is_sequenced(cmd_code);
    ev_mismatch = cmd_wr && !busy && pexp.valid && (pexp.ph != bus_phase);
    start       = cmd_wr && !busy && is_sequenced(cmd_code) && !ev_mismatch;
    ev_arb_lost = busy && (cur_op == OP_ARB) && arb_lost && !ev_soft_rst;
    abort       = ev_arb_lost || sel_expire;
    finish      = busy && xfer_done && !abort && !ev_soft_rst;
    ev_done     = finish || (cmd_wr && is_control(cmd_code) && !ev_soft_rst);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cur_op <= OP_NOP;
      par_en <= 1'b0;
      rsl_en <= 1'b0;
    end else if (ev_soft_rst) begin
      busy   <= 1'b0;
      cur_op <= OP_NOP;
      par_en <= 1'b0;
      rsl_en <= 1'b0;
    end else begin
      if (start) begin
        busy   <= 1'b1;
        cur_op <= cmd_code;
      end else if (busy && (xfer_done || abort)) begin
        busy <= 1'b0;
      end
      if (cmd_wr) begin
        case (cmd_code)
          OP_PAR_ON:  par_en <= 1'b1;
          OP_PAR_OFF: par_en <= 1'b0;
          OP_RSL_ON:  rsl_en <= 1'b1;
          OP_RSL_OFF: rsl_en <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scsi_pi_seltimer.sv
`timescale 1ns/1ps
module scsi_pi_seltimer #(
  parameter int TICK_CYCLES = 500000,
  parameter int LIMIT_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expire
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]   pre_q;
  logic [LIMIT_W-1:0] units_q;
  logic               tick;

  assign tick   = run && (pre_q == PRE_LAST);
  assign expire = tick && (limit != '0) && ((units_q + 1'b1) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (!run) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (tick) begin
      pre_q   <= '0;
      units_q <= units_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/scsi_pi_regs.sv
`timescale 1ns/1ps
module scsi_pi_regs #(
  parameter int REG_W   = 8,
  parameter int INT_W   = 3,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic [REG_W-1:0]   exc_set,
  input  logic [REG_W-1:0]   err_set,
  input  logic               done_set,
  input  logic [REG_W-1:0]   exc_clr,
  input  logic [REG_W-1:0]   err_clr,
  input  logic               done_clr,
  input  logic               mask_wr,
  input  logic [INT_W-1:0]   mask_din,
  input  logic               tmo_wr,
  input  logic [LIMIT_W-1:0] tmo_din,
  output logic [REG_W-1:0]   exc_q,
  output logic [REG_W-1:0]   err_q,
  output logic [INT_W-1:0]   int_src,
  output logic [LIMIT_W-1:0] tmo_q,
  output logic               irq
);
  logic             done_q;
  logic [INT_W-1:0] mask_q;

  assign int_src = {|err_q, |exc_q, done_q};
  assign irq     = |(int_src & mask_q);

  // status: a set wins over a clear landing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q  <= '0;
      err_q  <= '0;
      done_q <= 1'b0;
    end else if (soft_rst) begin
      exc_q  <= '0;
      err_q  <= '0;
      done_q <= 1'b0;
    end else begin
      exc_q  <= (exc_q & ~exc_clr) | exc_set;
      err_q  <= (err_q & ~err_clr) | err_set;
      done_q <= (done_q & ~done_clr) | done_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      tmo_q  <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_din;
      if (tmo_wr)  tmo_q  <= tmo_din;
    end
  end
endmodule

// File: rtl/scsi_phase_irq.sv
`timescale 1ns/1ps
module scsi_phase_irq
  import scsi_pi_pkg::*;
#(
  parameter int TICK_CYCLES = 500000,
  parameter int TMO_W       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_code,
  input  logic [2:0] bus_phase,
  input  logic       xfer_done,
  input  logic       arb_lost,
  input  logic       sel_atn_in,
  input  logic       sel_in,
  input  logic       resel_in,
  input  logic       disc_in,
  input  logic       bus_rst_in,
  input  logic       parity_err_in,
  input  logic       reg_wr,
  input  logic [2:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] exc_status,
  output logic [7:0] err_status,
  output logic [2:0] int_status,
  output logic       irq,
  output logic       busy
);
  localparam int REG_W = 8;
  localparam int INT_W = 3;

  // named internal events
  logic [CODE_W-1:0] cur_op;
  logic sel_run, par_en, rsl_en;
  logic ev_mismatch, ev_seqerr, ev_done, ev_arb_lost, ev_soft_rst;
  logic sel_expire;
  logic [TMO_W-1:0] tmo_val;
  logic [REG_W-1:0] exc_set, err_set, exc_clr, err_clr;
  logic done_clr, mask_wr, tmo_wr;

  scsi_pi_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .bus_phase(bus_phase), .xfer_done(xfer_done), .arb_lost(arb_lost),
    .sel_expire(sel_expire), .busy(busy), .cur_op(cur_op), .sel_run(sel_run),
    .par_en(par_en), .rsl_en(rsl_en), .ev_mismatch(ev_mismatch),
    .ev_seqerr(ev_seqerr), .ev_done(ev_done), .ev_arb_lost(ev_arb_lost),
    .ev_soft_rst(ev_soft_rst)
  );

  scsi_pi_seltimer #(.TICK_CYCLES(TICK_CYCLES), .LIMIT_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(sel_run), .limit(tmo_val), .expire(sel_expire)
  );

  always_comb begin
    exc_set             = '0;
    exc_set[EXC_SELATN] = sel_atn_in;
    exc_set[EXC_SELECT] = sel_in;
    exc_set[EXC_RESEL]  = resel_in && rsl_en;
    exc_set[EXC_ARBLST] = ev_arb_lost;
    exc_set[EXC_MISM]   = ev_mismatch;
    exc_set[EXC_SELTO]  = sel_expire;
    err_set             = '0;
    err_set[ERR_DISC]   = disc_in;
    err_set[ERR_BUSRST] = bus_rst_in;
    err_set[ERR_SEQ]    = ev_seqerr;
    err_set[ERR_PAR]    = parity_err_in && par_en;
    exc_clr  = (reg_wr && reg_sel == 3'd0) ? reg_wdata : '0;
    err_clr  = (reg_wr && reg_sel == 3'd1) ? reg_wdata : '0;
    done_clr = reg_wr && (reg_sel == 3'd2) && reg_wdata[0];
    mask_wr  = reg_wr && (reg_sel == 3'd3);
    tmo_wr   = reg_wr && (reg_sel == 3'd4);
  end

  scsi_pi_regs #(.REG_W(REG_W), .INT_W(INT_W), .LIMIT_W(TMO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(ev_soft_rst),
    .exc_set(exc_set), .err_set(err_set), .done_set(ev_done),
    .exc_clr(exc_clr), .err_clr(err_clr), .done_clr(done_clr),
    .mask_wr(mask_wr), .mask_din(reg_wdata[INT_W-1:0]),
    .tmo_wr(tmo_wr), .tmo_din(reg_wdata[TMO_W-1:0]),
    .exc_q(exc_status), .err_q(err_status), .int_src(int_status),
    .tmo_q(tmo_val), .irq(irq)
  );
endmodule

// File: rtl/scsi_phase_irq_chk.sv
`timescale 1ns/1ps
module scsi_phase_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [3:0] cmd_code,
  input logic       xfer_done,
  input logic       arb_lost,
  input logic       busy,
  input logic [3:0] cur_op,
  input logic [7:0] exc_status,
  input logic [7:0] err_status,
  input logic [2:0] int_status,
  input logic       ev_mismatch,
  input logic       ev_soft_rst,
  input logic       sel_expire
);
  logic soft_cmd;
  assign soft_cmd = cmd_wr && (cmd_code == 4'hE);

  // R2
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done && !arb_lost && !sel_expire && !soft_cmd) |=> (!busy && int_status[0]));

  // R3
  mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> (exc_status[1] && !busy));

  // R4
  seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && cmd_code >= 4'h1 && cmd_code <= 4'h9) |=> err_status[4]);

  // R5
  sel_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_expire && !soft_cmd) |=> (exc_status[0] && !busy));

  // R6
  arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op == 4'h1 && arb_lost && !soft_cmd) |=> (!busy && exc_status[2]));

  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_rst |=> (exc_status == 8'h00 && err_status == 8'h00 && !busy && !int_status[0]));
endmodule

bind scsi_phase_irq scsi_phase_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
  .xfer_done(xfer_done), .arb_lost(arb_lost), .busy(busy), .cur_op(cur_op),
  .exc_status(exc_status), .err_status(err_status), .int_status(int_status),
  .ev_mismatch(ev_mismatch), .ev_soft_rst(ev_soft_rst), .sel_expire(sel_expire)
);

// File: tb/scsi_phase_irq_test.sv
`timescale 1ns/1ps
module scsi_phase_irq_test;
  localparam int TICK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [2:0] bus_phase = '0;
  logic xfer_done = 1'b0, arb_lost = 1'b0, sel_atn_in = 1'b0, sel_in = 1'b0;
  logic resel_in = 1'b0, disc_in = 1'b0, bus_rst_in = 1'b0, parity_err_in = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] exc_status, err_status;
  logic [2:0] int_status;
  logic irq, busy;

  always #2.5 clk = ~clk;

  scsi_phase_irq #(.TICK_CYCLES(TICK), .TMO_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .bus_phase(bus_phase), .xfer_done(xfer_done), .arb_lost(arb_lost),
    .sel_atn_in(sel_atn_in), .sel_in(sel_in), .resel_in(resel_in),
    .disc_in(disc_in), .bus_rst_in(bus_rst_in), .parity_err_in(parity_err_in),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .exc_status(exc_status), .err_status(err_status), .int_status(int_status),
    .irq(irq), .busy(busy)
  );

  typedef struct {
    string      tag;
    logic [7:0] exc;
    logic [7:0] err;
    logic [2:0] intr;
    logic       irq;
    logic       busy;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic void expect_st(string tag, logic [7:0] e, logic [7:0] r,
                                    logic [2:0] i, logic q, logic b);
    exp_t x;
    x.tag = tag; x.exc = e; x.err = r; x.intr = i; x.irq = q; x.busy = b;
    exp_q.push_back(x);
  endfunction

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      checks++;
      if (exc_status !== x.exc || err_status !== x.err || int_status !== x.intr ||
          irq !== x.irq || busy !== x.busy) begin
        errors++;
        $display("FAIL %s: actual exc=%h err=%h int=%b irq=%b busy=%b expected exc=%h err=%h int=%b irq=%b busy=%b",
                 x.tag, exc_status, err_status, int_status, irq, busy,
                 x.exc, x.err, x.intr, x.irq, x.busy);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
    cmd_wr = 0; xfer_done = 0; arb_lost = 0; sel_atn_in = 0; sel_in = 0;
    resel_in = 0; disc_in = 0; bus_rst_in = 0; parity_err_in = 0; reg_wr = 0;
  endtask

  task automatic cmd(input logic [3:0] c);
    cmd_wr = 1; cmd_code = c;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R0 watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    expect_st("R1 reset state", 8'h00, 8'h00, 3'b000, 0, 0); step();
    wr(3, 8'h07); expect_st("R10 mask write", 8'h00, 8'h00, 3'b000, 0, 0); step();

    // R2 matching phase command
    bus_phase = 3'b010; cmd(4'h3);
    expect_st("R2 command starts", 8'h00, 8'h00, 3'b000, 0, 1); step();
    xfer_done = 1; expect_st("R2 done ends busy", 8'h00, 8'h00, 3'b001, 1, 0); step();
    wr(2, 8'h01); expect_st("R9 done cleared", 8'h00, 8'h00, 3'b000, 0, 0); step();

    // R3 mismatch
    cmd(4'h4); expect_st("R3 phase mismatch", 8'h02, 8'h00, 3'b010, 1, 0); step();
    wr(2, 8'h07); expect_st("R9 int clear no effect", 8'h02, 8'h00, 3'b010, 1, 0); step();
    wr(0, 8'h02); expect_st("R11 exc clear", 8'h00, 8'h00, 3'b000, 0, 0); step();

    // R4 sequence error
    bus_phase = 3'b000; cmd(4'h5);
    expect_st("R4 data out starts", 8'h00, 8'h00, 3'b000, 0, 1); step();
    cmd(4'h6); expect_st("R4 seq error", 8'h00, 8'h10, 3'b100, 1, 1); step();
    xfer_done = 1; expect_st("R4 first cmd completes", 8'h00, 8'h10, 3'b101, 1, 0); step();
    wr(1, 8'h10); expect_st("R11 err clear", 8'h00, 8'h00, 3'b001, 1, 0); step();
    wr(2, 8'h01); expect_st("R9 clear done", 8'h00, 8'h00, 3'b000, 0, 0); step();

    // R6 arbitration
    cmd(4'h1); expect_st("R6 arb starts", 8'h00, 8'h00, 3'b000, 0, 1); step();
    arb_lost = 1; expect_st("R6 arb lost", 8'h04, 8'h00, 3'b010, 1, 0); step();
    wr(0, 8'h04); expect_st("R6 clear", 8'h00, 8'h00, 3'b000, 0, 0); step();
    arb_lost = 1; expect_st("R6 idle arb_lost ignored", 8'h00, 8'h00, 3'b000, 0, 0); step();

    // R5 selection timeout, L=3
    wr(4, 8'd3); step();
    cmd(4'h2); expect_st("R5 select starts", 8'h00, 8'h00, 3'b000, 0, 1); step();
    repeat (10) step();
    expect_st("R5 one cycle before timeout", 8'h00, 8'h00, 3'b000, 0, 1); step();
    expect_st("R5 timeout", 8'h01, 8'h00, 3'b010, 1, 0); step();
    wr(0, 8'h01); step();
    wr(4, 8'd0); step();
    cmd(4'h2); step();
    repeat (30) step();
    expect_st("R5 zero timeout never fires", 8'h00, 8'h00, 3'b000, 0, 1); step();
    xfer_done = 1; expect_st("R5 select done", 8'h00, 8'h00, 3'b001, 1, 0); step();
    wr(2, 8'h01); step();

    // R7 target/reselect events
    sel_atn_in = 1; expect_st("R7 sel with atn", 8'h20, 8'h00, 3'b010, 1, 0); step();
    sel_in = 1; expect_st("R7 selected", 8'h30, 8'h00, 3'b010, 1, 0); step();
    resel_in = 1; expect_st("R7 resel disabled", 8'h30, 8'h00, 3'b010, 1, 0); step();
    cmd(4'hC); expect_st("R12 resel enable done", 8'h30, 8'h00, 3'b011, 1, 0); step();
    resel_in = 1; expect_st("R7 resel enabled", 8'h38, 8'h00, 3'b011, 1, 0); step();
    wr(0, 8'h38); expect_st("R11 clear three", 8'h00, 8'h00, 3'b001, 1, 0); step();
    sel_in = 1; wr(0, 8'h10);
    expect_st("R11 set beats clear", 8'h10, 8'h00, 3'b011, 1, 0); step();
    wr(0, 8'h10); step();
    cmd(4'hD); step();
    resel_in = 1; expect_st("R7 resel disabled again", 8'h00, 8'h00, 3'b001, 1, 0); step();
    wr(2, 8'h01); step();

    // R8 errors
    disc_in = 1; expect_st("R8 disconnect", 8'h00, 8'h40, 3'b100, 1, 0); step();
    bus_rst_in = 1; expect_st("R8 bus reset", 8'h00, 8'h60, 3'b100, 1, 0); step();
    parity_err_in = 1; expect_st("R8 parity disabled", 8'h00, 8'h60, 3'b100, 1, 0); step();
    cmd(4'hA); expect_st("R12 parity enable done", 8'h00, 8'h60, 3'b101, 1, 0); step();
    parity_err_in = 1; expect_st("R8 parity enabled", 8'h00, 8'h61, 3'b101, 1, 0); step();
    cmd(4'hE); expect_st("R12 soft reset", 8'h00, 8'h00, 3'b000, 0, 0); step();
    parity_err_in = 1; expect_st("R12 parity off after reset", 8'h00, 8'h00, 3'b000, 0, 0); step();

    // R12 nop and flush
    cmd(4'h0); expect_st("R12 code 0 ignored", 8'h00, 8'h00, 3'b000, 0, 0); step();
    cmd(4'hF); expect_st("R12 flush done", 8'h00, 8'h00, 3'b001, 1, 0); step();
    wr(2, 8'h01); step();

    // R10 masking
    wr(3, 8'h00); step();
    disc_in = 1; expect_st("R10 masked off", 8'h00, 8'h40, 3'b100, 0, 0); step();
    wr(3, 8'h04); expect_st("R10 error enabled", 8'h00, 8'h40, 3'b100, 1, 0); step();
    wr(3, 8'h03); expect_st("R10 other bits only", 8'h00, 8'h40, 3'b100, 0, 0); step();
    wr(1, 8'h40); expect_st("R11 final clear", 8'h00, 8'h00, 3'b000, 0, 0); step();
    step();

    finished = 1;
    summary();
    $finish;
  end
endmodule